// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal requester and an external 8K x 8 asynchronous static RAM that shares one bidirectional data bus for reads and writes. The memory is selected by two chip enables: one is active low and one is active high. It also has an active-low output enable and an active-low write enable. The controller is a synchronous state machine. It turns each single-cycle request into a pin sequence on the memory side, and every phase of that sequence lasts a whole number of clock cycles.

Each wait count is the ceiling of a nanosecond parameter divided by the clock period, with a floor of one cycle. These counts cover:
- address and output-enable access,
- the minimum cycle time,
- the write pulse and data setup,
- the bus release after a read,
- the wake-up delay after power-down.

Every memory control pin comes straight from a flop. While the standby input is high, the controller keeps the memory deselected. Requests are accepted only when the controller is idle, and each accepted access ends with a one-cycle done pulse.

Top module: `sramc_top`

## Requirements
- R1: While in reset, and while asleep under standby, the pins are memCe1N=1, memCe2=0, memOeN=1 and memWeN=1. The data bus is released (all bits Z) and done is 0.
- R2: After standby falls, both enables go active on the next clock edge. The controller then stays idle-selected (memOeN=1, memWeN=1) for ceil(T_WAKE_NS/CLK_PERIOD_NS) cycles before it can accept a request.
- R3: An accepted read (reqWrite=0) drives memAddr with the request address and holds memCe1N=0, memCe2=1, memOeN=0, memWeN=1. This lasts for the largest of the ceilings of the address access time, the output-enable access time and the cycle time. The controller never drives the bus while memOeN is 0.
- R4: The byte on the bus is captured on the last read cycle. It appears on rdData together with done and holds until the next read completes. Writes do not change it.
- R5: An accepted write (reqWrite=1) holds memWeN=0 for the largest of the ceilings of the write pulse, the data setup and the cycle time. memOeN stays 1 throughout. The bus carries reqWdata from the cycle in which memWeN falls through exactly one cycle after memWeN rises, and is then released.
- R6: After a read, memOeN returns to 1 and no new access starts for ceil(T_BUS_RELEASE_NS/CLK_PERIOD_NS) cycles.
- R7: A request is taken only in the idle state. A request seen while asleep, waking or mid-access is dropped. If standby and a request arrive in the same idle cycle, standby wins and the request is dropped.
- R8: If standby rises during an access, that access completes, done is pulsed, and only then is the memory deselected.
- R9: done is high for exactly one cycle per accepted access. For a read, it is the first cycle after the read phase. For a write, it is the cycle in which memWeN has just risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Power-down request; deselects the memory |
| reqValid | input | 1 | Single-cycle access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write byte |
| rdData | output | DATA_W | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | ADDR_W | Memory address |
| memData | inout | DATA_W | Shared data bus |

## Verification
The properties assume that the external memory drives the bus only in its read-selected state. They also assume that reset is released away from a clock edge. The bench memory model follows both rules: it drives only while both enables are active, output enable is low and write enable is high, and reset is released at a falling clock edge. Requests are single-cycle pulses that change at falling clock edges. Some are deliberately issued during wake-up, mid-access, and in the same cycle as standby, so that the dropping rules are exercised rather than assumed.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  function automatic int unsigned waitCycles(input int unsigned tNs, input int unsigned periodNs);
    int unsigned c;
    c = (tNs + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_IDLE,
    ST_READ,
    ST_READ_OFF,
    ST_WRITE,
    ST_WRITE_END
  } phase_e;

  typedef struct packed {
    logic load;
    logic capture;
  } dp_strobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned T_ADDR_ACCESS_NS = 55,
  parameter int unsigned T_OE_ACCESS_NS   = 30,
  parameter int unsigned T_CYCLE_NS       = 55,
  parameter int unsigned T_WE_PULSE_NS    = 40,
  parameter int unsigned T_DATA_SETUP_NS  = 25,
  parameter int unsigned T_BUS_RELEASE_NS = 20,
  parameter int unsigned T_WAKE_NS        = 55
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       standby,
  input  logic       reqValid,
  input  logic       reqWrite,
  output dp_strobe_t strobe,
  output logic       done,
  output logic       ce1N,
  output logic       ce2,
  output logic       oeN,
  output logic       weN,
  output logic       busDrive
);

  localparam int unsigned C_RD   = maxOf3(waitCycles(T_ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                          waitCycles(T_OE_ACCESS_NS, CLK_PERIOD_NS),
                                          waitCycles(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int unsigned C_WR   = maxOf3(waitCycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                          waitCycles(T_DATA_SETUP_NS, CLK_PERIOD_NS),
                                          waitCycles(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int unsigned C_OFF  = waitCycles(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WAKE = waitCycles(T_WAKE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_MAX  = maxOf3(maxOf3(C_RD, C_WR, C_OFF), C_WAKE, 1);
  localparam int unsigned CNT_W  = $clog2(C_MAX + 1);

  phase_e           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cntZero;
  logic             accept;
  logic             doneNext;
  logic             selNext;

  assign cntZero = (cnt == '0);
  assign accept  = (state == ST_IDLE) && reqValid && !standby;

  always_comb begin
    stateNext = state;
    cntNext   = cntZero ? cnt : cnt - CNT_W'(1);
    case (state)
      ST_SLEEP: begin
        if (!standby) begin
          stateNext = ST_WAKE;
          cntNext   = CNT_W'(C_WAKE - 1);
        end
      end
      ST_WAKE: begin
        if (standby)      stateNext = ST_SLEEP;
        else if (cntZero) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (standby) begin
          stateNext = ST_SLEEP;
        end else if (reqValid) begin
          if (reqWrite) begin
            stateNext = ST_WRITE;
            cntNext   = CNT_W'(C_WR - 1);
          end else begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(C_RD - 1);
          end
        end
      end
      ST_READ: begin
        if (cntZero) begin
          stateNext = ST_READ_OFF;
          cntNext   = CNT_W'(C_OFF - 1);
        end
      end
      ST_READ_OFF: begin
        if (cntZero) stateNext = ST_IDLE;
      end
      ST_WRITE: begin
        if (cntZero) stateNext = ST_WRITE_END;
      end
      ST_WRITE_END: stateNext = ST_IDLE;
      default:      stateNext = ST_SLEEP;
    endcase
  end

  assign doneNext       = ((state == ST_READ) || (state == ST_WRITE)) && cntZero;
  assign selNext        = (stateNext != ST_SLEEP);
  assign strobe.load    = accept;
  assign strobe.capture = (state == ST_READ) && cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SLEEP;
      cnt      <= '0;
      done     <= 1'b0;
      ce1N     <= 1'b1;
      ce2      <= 1'b0;
      oeN      <= 1'b1;
      weN      <= 1'b1;
      busDrive <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      done     <= doneNext;
      ce1N     <= !selNext;
      ce2      <= selNext;
      oeN      <= (stateNext != ST_READ);
      weN      <= (stateNext != ST_WRITE);
      busDrive <= (stateNext == ST_WRITE) || (stateNext == ST_WRITE_END);
    end
  end

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      busOut  <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        memAddr <= reqAddr;
        busOut  <= reqWdata;
      end
      if (strobe.capture) rdData <= busIn;
    end
  end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W           = 13,
  parameter int unsigned DATA_W           = 8,
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned T_ADDR_ACCESS_NS = 55,
  parameter int unsigned T_OE_ACCESS_NS   = 30,
  parameter int unsigned T_CYCLE_NS       = 55,
  parameter int unsigned T_WE_PULSE_NS    = 40,
  parameter int unsigned T_DATA_SETUP_NS  = 25,
  parameter int unsigned T_BUS_RELEASE_NS = 20,
  parameter int unsigned T_WAKE_NS        = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData
);

  dp_strobe_t        strobe;
  logic              busDrive;
  logic [DATA_W-1:0] busOut;

  sramc_ctrl #(
    .CLK_PERIOD_NS   (CLK_PERIOD_NS),
    .T_ADDR_ACCESS_NS(T_ADDR_ACCESS_NS),
    .T_OE_ACCESS_NS  (T_OE_ACCESS_NS),
    .T_CYCLE_NS      (T_CYCLE_NS),
    .T_WE_PULSE_NS   (T_WE_PULSE_NS),
    .T_DATA_SETUP_NS (T_DATA_SETUP_NS),
    .T_BUS_RELEASE_NS(T_BUS_RELEASE_NS),
    .T_WAKE_NS       (T_WAKE_NS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .standby (standby),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe),
    .done    (done),
    .ce1N    (memCe1N),
    .ce2     (memCe2),
    .oeN     (memOeN),
    .weN     (memWeN),
    .busDrive(busDrive)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .busIn   (memData),
    .memAddr (memAddr),
    .busOut  (busOut),
    .rdData  (rdData)
  );

  assign memData = busDrive ? busOut : {DATA_W{1'bz}};

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk
  import sramc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned T_ADDR_ACCESS_NS = 55,
  parameter int unsigned T_OE_ACCESS_NS   = 30,
  parameter int unsigned T_CYCLE_NS       = 55,
  parameter int unsigned T_WE_PULSE_NS    = 40,
  parameter int unsigned T_DATA_SETUP_NS  = 25,
  parameter int unsigned T_BUS_RELEASE_NS = 20,
  parameter int unsigned T_WAKE_NS        = 55
) (
  input logic clk,
  input logic rstN,
  input logic ce1N,
  input logic ce2,
  input logic oeN,
  input logic weN,
  input logic busDrive,
  input logic done
);

  localparam int unsigned C_RD   = maxOf3(waitCycles(T_ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                          waitCycles(T_OE_ACCESS_NS, CLK_PERIOD_NS),
                                          waitCycles(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int unsigned C_WR   = maxOf3(waitCycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                          waitCycles(T_DATA_SETUP_NS, CLK_PERIOD_NS),
                                          waitCycles(T_CYCLE_NS, CLK_PERIOD_NS));
  localparam int unsigned C_OFF  = waitCycles(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WAKE = waitCycles(T_WAKE_NS, CLK_PERIOD_NS);
  localparam int unsigned SAT    = 100000;

  int unsigned oeRun, weRun, sinceOe, ceRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeRun   <= 0;
      weRun   <= 0;
      sinceOe <= SAT;
      ceRun   <= 0;
    end else begin
      oeRun   <= !oeN ? ((oeRun < SAT) ? oeRun + 1 : oeRun) : 0;
      weRun   <= !weN ? ((weRun < SAT) ? weRun + 1 : weRun) : 0;
      sinceOe <= !oeN ? 0 : ((sinceOe < SAT) ? sinceOe + 1 : sinceOe);
      ceRun   <= !ce1N ? ((ceRun < SAT) ? ceRun + 1 : ceRun) : 0;
    end
  end

  // R1: a deselected memory sees no output or write strobe and no bus drive
  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    ce1N |-> (!ce2 && oeN && weN && !busDrive));

  // R2: first strobe only after the wake window
  p_wake_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(oeN) || $fell(weN)) |-> (ceRun >= C_WAKE));

  // R3: read strobe lasts the whole read window
  p_read_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeN) |-> (oeRun >= C_RD));

  // R3: controller never fights the memory
  p_no_bus_fight_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && !ce1N && ce2) |-> !busDrive);

  // R5: write strobe lasts the whole write window
  p_write_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (weRun >= C_WR));

  // R5: output enable held high and data driven while writing
  p_write_oe_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (oeN && busDrive));

  // R5: bus released one cycle after the write strobe ends
  p_drive_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && weN) |=> !busDrive);

  // R6: no drive until the memory has let go of the bus
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDrive) |-> (sinceOe >= C_OFF));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind sramc_top sramc_chk #(
  .CLK_PERIOD_NS   (CLK_PERIOD_NS),
  .T_ADDR_ACCESS_NS(T_ADDR_ACCESS_NS),
  .T_OE_ACCESS_NS  (T_OE_ACCESS_NS),
  .T_CYCLE_NS      (T_CYCLE_NS),
  .T_WE_PULSE_NS   (T_WE_PULSE_NS),
  .T_DATA_SETUP_NS (T_DATA_SETUP_NS),
  .T_BUS_RELEASE_NS(T_BUS_RELEASE_NS),
  .T_WAKE_NS       (T_WAKE_NS)
) u_sramc_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ce1N    (memCe1N),
  .ce2     (memCe2),
  .oeN     (memOeN),
  .weN     (memWeN),
  .busDrive(busDrive),
  .done    (done)
);

// File: tb/tb_sramc_top.sv
module tb_sramc_top;

  localparam int PERIOD = 20;
  localparam int P_SLEEP = 0, P_WAKE = 1, P_IDLE = 2, P_RD = 3, P_RDOFF = 4, P_WR = 5, P_WREND = 6;

  function automatic int ceilC(input int t);
    int c;
    c = (t + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int big(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (c > m) ? c : m;
  endfunction

  int cRd, cWr, cOff, cWake;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        standby = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rdData;
  logic        done;
  logic        memCe1N, memCe2, memOeN, memWeN;
  logic [12:0] memAddr;
  wire  [7:0]  memData;

  sramc_top dut (
    .clk(clk), .rstN(rstN), .standby(standby), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData), .done(done),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memData(memData)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural memory on the pins
  logic [7:0] sram   [0:8191];
  logic [7:0] refMem [0:8191];
  logic       memReads;
  assign memReads = !memCe1N && memCe2 && !memOeN && memWeN;
  assign memData  = memReads ? sram[memAddr] : 8'bz;
  always @(posedge memWeN) if (memCe1N === 1'b0 && memCe2 === 1'b1) sram[memAddr] = memData;

  // reference model
  int          ph;
  int          rem;
  logic        expDone;
  logic [12:0] mAddr;
  logic [7:0]  mData;
  logic [7:0]  expRd;
  logic        anyRead;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph = P_SLEEP; rem = 0; expDone = 1'b0; expRd = 8'h00; anyRead = 1'b0;
    end else begin
      expDone = 1'b0;
      case (ph)
        P_SLEEP: if (!standby) begin ph = P_WAKE; rem = cWake; end
        P_WAKE: begin
          if (standby) ph = P_SLEEP;
          else if (rem == 1) ph = P_IDLE;
          else rem = rem - 1;
        end
        P_IDLE: begin
          if (standby) ph = P_SLEEP;
          else if (reqValid) begin
            mAddr = reqAddr; mData = reqWdata;
            if (reqWrite) begin ph = P_WR; rem = cWr; refMem[reqAddr] = reqWdata; end
            else begin ph = P_RD; rem = cRd; end
          end
        end
        P_RD: begin
          if (rem == 1) begin
            ph = P_RDOFF; rem = cOff; expDone = 1'b1; expRd = refMem[mAddr]; anyRead = 1'b1;
          end else rem = rem - 1;
        end
        P_RDOFF: if (rem == 1) ph = P_IDLE; else rem = rem - 1;
        P_WR: if (rem == 1) begin ph = P_WREND; expDone = 1'b1; end else rem = rem - 1;
        default: ph = P_IDLE;
      endcase
    end
  end

  int    nChecks = 0;
  int    nFails  = 0;
  string scen    = "R1";
  logic  comparing = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s (scenario %s) at %0t: actual=%0h expected=%0h", req, scen, $time, act, exp);
    end
  endtask

  function automatic string phTag(input int p);
    case (p)
      P_SLEEP: return "R1";
      P_WAKE:  return "R2";
      P_RD:    return "R3";
      P_RDOFF: return "R6";
      P_WR, P_WREND: return "R5";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (comparing) begin
      logic eCe1N, eCe2, eOeN, eWeN;
      string t;
      t     = phTag(ph);
      eCe1N = (ph == P_SLEEP);
      eCe2  = (ph != P_SLEEP);
      eOeN  = (ph != P_RD);
      eWeN  = (ph != P_WR);
      check({memCe1N, memCe2, memOeN, memWeN} === {eCe1N, eCe2, eOeN, eWeN}, t,
            {memCe1N, memCe2, memOeN, memWeN}, {eCe1N, eCe2, eOeN, eWeN});
      if (ph == P_WR || ph == P_WREND)
        check(memData === mData, "R5", memData, mData);
      else if (ph == P_RD)
        check(memData === refMem[mAddr], "R3", memData, refMem[mAddr]);
      else
        check(memData === 8'bz, t, memData, 0);
      if (ph >= P_RD)
        check(memAddr === mAddr, t, memAddr, mAddr);
      check(done === expDone, "R9", done, expDone);
      if (anyRead) check(rdData === expRd, "R4", rdData, expRd);
    end
  end

  task automatic waitIdle();
    while (ph != P_IDLE) @(negedge clk);
  endtask

  task automatic access(input logic w, input logic [12:0] a, input logic [7:0] d);
    waitIdle();
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog (scenario %s): actual=hung expected=finished", scen);
    summary();
  end

  initial begin
    cRd   = big(ceilC(55), ceilC(30), ceilC(55));
    cWr   = big(ceilC(40), ceilC(25), ceilC(55));
    cOff  = ceilC(20);
    cWake = ceilC(55);
    for (int i = 0; i < 8192; i++) begin
      sram[i]   = 8'(i * 37 + 5);
      refMem[i] = 8'(i * 37 + 5);
    end
    #2 rstN = 1'b0;
    repeat (3) @(negedge clk);
    comparing = 1'b1;
    // R1: reset state
    check({memCe1N, memCe2, memOeN, memWeN, done} === 5'b10110, "R1",
          {memCe1N, memCe2, memOeN, memWeN, done}, 5'b10110);
    check(memData === 8'bz, "R1", memData, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 / R7: wake, request during the wake window is dropped
    scen = "R2";
    standby = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0010; reqWdata = 8'h99;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();

    scen = "R5";
    access(1'b1, 13'h0000, 8'hA5);
    access(1'b1, 13'h1FFF, 8'h3C);
    access(1'b1, 13'h0155, 8'hFF);
    access(1'b1, 13'h1AAA, 8'h00);

    scen = "R3";
    access(1'b0, 13'h0000, 8'h00);
    access(1'b0, 13'h1FFF, 8'h00);
    access(1'b0, 13'h0155, 8'h00);
    access(1'b0, 13'h1AAA, 8'h00);
    access(1'b0, 13'h0800, 8'h00);
    access(1'b0, 13'h0010, 8'h00);  // R7: never written

    scen = "R6";
    access(1'b1, 13'h0042, 8'h5A);
    access(1'b0, 13'h0042, 8'h00);
    access(1'b1, 13'h0043, 8'hC3);
    check(rdData === 8'h5A, "R4", rdData, 8'h5A);

    // R7: request while a read is in flight is dropped
    scen = "R7";
    waitIdle();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'h0043; reqWdata = 8'h00;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0043; reqWdata = 8'h11;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    access(1'b0, 13'h0043, 8'h00);
    check(rdData === 8'hC3, "R7", rdData, 8'hC3);

    // R7: standby wins over a simultaneous request
    standby = 1'b1; reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0077; reqWdata = 8'hEE;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(memCe1N === 1'b1, "R7", memCe1N, 1);
    standby = 1'b0;
    waitIdle();
    access(1'b0, 13'h0077, 8'h00);
    check(rdData === refMem[13'h0077], "R7", rdData, refMem[13'h0077]);

    // R8: standby during a write lets it finish
    scen = "R8";
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0500; reqWdata = 8'h6D;
    @(negedge clk);
    reqValid = 1'b0; standby = 1'b1;
    while (ph != P_SLEEP) @(negedge clk);
    repeat (2) @(negedge clk);
    standby = 1'b0;
    waitIdle();
    access(1'b0, 13'h0500, 8'h00);
    check(rdData === 8'h6D, "R8", rdData, 8'h6D);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule